// File: doc/BRIEF.md
# One-Bit Delta-Sigma Audio DAC

This block turns a stream of signed audio samples into a single pulse-density bit. The bit then needs only a simple analog low-pass filter to become an audio voltage. Each sample is flipped to offset binary and held in a register. On every modulator step the held value is added to a wrapping accumulator. The carry out of that addition becomes the output bit for the step, so the fraction of ones follows the sample value.

Samples arrive at the audio rate, for example 48 kHz, with a one-cycle valid strobe. The modulator step comes from a clock-enable input that runs much faster. An oversampling ratio of 256 over 48 kHz gives 12.288 MHz, which is one eighth of a 98.304 MHz system clock. The accumulator is as wide as the sample, 16 bits by default.

Top module: `pdm_dsm_dac`

## Requirements
- R1: While reset is asserted the output is 0 and the accumulator is 0. The held value resets to midscale 2^(W-1), which is signed zero. So the first steps after reset give the bits 0,1,0,1.
- R2: The held value is the signed input with its most significant bit inverted. Code -2^(W-1) maps to 0, and code 2^(W-1)-1 maps to 2^W-1.
- R3: On each cycle with `step_en_i` high, the held value is added to the accumulator modulo 2^W.
- R4: The output bit is registered. After a step it equals the carry out of that step's addition. In cycles without a step it holds its value.
- R5: A sample is taken only in a cycle with `sample_valid_i` high. Changes on `sample_i` while the strobe is low have no effect on the output.
- R6: When a strobe and a step fall in the same cycle, that step uses the previously held value. The new sample takes effect from the next step on.
- R7: Over any 2^W consecutive steps with a constant held value u, the output carries exactly u ones.
- R8: The sample and accumulator width W is a parameter with a default of 16.
- R9: The most negative sample never gives a 1. The most positive sample gives 2^W-1 ones in every 2^W steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed two's-complement audio sample |
| sample_valid_i | input | 1 | Strobe that loads `sample_i` into the hold register |
| step_en_i | input | 1 | Modulator step enable (oversampling rate) |
| pdm_o | output | 1 | Pulse-density output bit |

## Verification
An 8-bit copy of the block is swept over every signed code. For each code the bench counts the ones over 256 steps, which separates a correct offset conversion and carry from an off-by-one or a missing MSB flip. Short runs compare the output bit for bit against an arithmetic model: right after reset, with steps withheld, with sample changes that carry no strobe, and with a strobe that coincides with a step. These runs tell apart the reset value, output holding, strobe gating and update ordering. A 16-bit copy checks the reset pattern and one full 65536-step density count at the default width.

// File: rtl/pdm_dsm_dac.sv
module pdm_dsm_dac #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sample_valid_i,
  input  logic                       step_en_i,
  output logic                       pdm_o
);

  localparam int W = SAMPLE_W;
  localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] held_q;
  logic [W-1:0] acc_q;
  logic [W:0]   sum;
  logic [W-1:0] offset_in;

  assign offset_in = {~sample_i[W-1], sample_i[W-2:0]};
  assign sum       = {1'b0, acc_q} + {1'b0, held_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= MIDSCALE;
    else if (sample_valid_i) held_q <= offset_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pdm_o <= 1'b0;
    end else if (step_en_i) begin
      acc_q <= sum[W-1:0];
      pdm_o <= sum[W];
    end
  end

endmodule

module pdm_dsm_dac_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sample_i,
  input logic         sample_valid_i,
  input logic         step_en_i,
  input logic         pdm_o,
  input logic [W-1:0] held_q,
  input logic [W-1:0] acc_q
);

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> (!pdm_o && acc_q == '0)); // R1

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en_i |=> $stable(pdm_o)); // R4

  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i |=> (pdm_o == (acc_q < $past(acc_q)))); // R3

  AST_LATCH_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_i |=> (held_q == $past({~sample_i[W-1], sample_i[W-2:0]}))); // R2

  AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid_i |=> $stable(held_q)); // R5

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && held_q == '0) |=> !pdm_o); // R9

endmodule

bind pdm_dsm_dac pdm_dsm_dac_chk #(.W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .sample_valid_i(sample_valid_i),
  .step_en_i(step_en_i), .pdm_o(pdm_o), .held_q(held_q), .acc_q(acc_q)
);

// File: tb/tb_pdm_dsm_dac.sv
module tb_pdm_dsm_dac;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic signed [7:0]  s8 = '0;
  logic               v8 = 1'b0, e8 = 1'b0, o8;
  logic signed [15:0] s16 = '0;
  logic               v16 = 1'b0, e16 = 1'b0, o16;

  pdm_dsm_dac #(.SAMPLE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sample_i(s8), .sample_valid_i(v8),
    .step_en_i(e8), .pdm_o(o8));

  pdm_dsm_dac dut_w16 (
    .clk(clk), .rst_n(rst_n), .sample_i(s16), .sample_valid_i(v16),
    .step_en_i(e16), .pdm_o(o16));

  int checks = 0, errors = 0;
  int m_acc = 0, m_u = 128;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Load a sample into the 8-bit copy; R2: offset = code ^ 0x80
  task automatic load8(input logic [7:0] code);
    s8 = code; v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    m_u = int'(code ^ 8'h80);
  endtask

  // Bit-exact steps against the arithmetic model (R3, R4)
  task automatic steps8(input int n, input string req);
    e8 = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_acc = m_acc + m_u;
      check(o8 == (m_acc >= 256), req, int'(o8), int'(m_acc >= 256));
      m_acc = m_acc % 256;
    end
    e8 = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ones;
    logic last;
    repeat (3) @(negedge clk);
    check(o8 == 1'b0, "R1 reset out w8", int'(o8), 0);
    check(o16 == 1'b0, "R1 reset out w16", int'(o16), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: midscale held, zero accumulator -> 0,1,0,1
    steps8(4, "R1 post-reset pattern w8");
    e16 = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(o16 == 1'(i % 2), "R1 post-reset pattern w16", int'(o16), i % 2);
    end
    e16 = 1'b0;

    // R3/R4 bit-exact with an odd value
    load8(8'sd37);
    steps8(40, "R3 carry sequence");

    // R4: output holds with no steps
    last = o8;
    repeat (5) @(negedge clk);
    check(o8 == last, "R4 hold without step", int'(o8), int'(last));

    // R5: sample changes without strobe ignored
    s8 = -8'sd100;
    repeat (3) @(negedge clk);
    s8 = 8'sd90;
    steps8(30, "R5 no strobe no effect");

    // R6: strobe coincides with a step -> old value used
    s8 = -8'sd55; v8 = 1'b1; e8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    m_acc = m_acc + m_u;
    check(o8 == (m_acc >= 256), "R6 same-cycle step uses old", int'(o8), int'(m_acc >= 256));
    m_acc = m_acc % 256;
    m_u = int'(8'(-8'sd55) ^ 8'h80);
    steps8(30, "R6 new value afterwards");

    // R7/R2/R9: exhaustive density sweep
    for (int s = -128; s < 128; s++) begin
      load8(8'(s));
      ones = 0;
      e8 = 1'b1;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        ones += int'(o8);
      end
      e8 = 1'b0;
      if (s == -128)      check(ones == 0,   "R9 most negative", ones, 0);
      else if (s == 127)  check(ones == 255, "R9 most positive", ones, 255);
      else                check(ones == s + 128, "R7 R2 density", ones, s + 128);
    end

    // R8: default width, full 2^16-step count
    s16 = 16'sh1234; v16 = 1'b1;
    @(negedge clk);
    v16 = 1'b0;
    ones = 0;
    e16 = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      ones += int'(o16);
    end
    e16 = 1'b0;
    check(ones == 32'h9234, "R8 R7 density w16", ones, 32'h9234);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule